// File: doc/BRIEF.md
# Fully Associative Write-Back Byte Cache

This block is a small byte-addressed cache that sits next to main memory. The processor issues one byte read or byte write at a time on a 12-bit address. The upper ten address bits form the line tag and the lower two bits pick the byte within a four-byte line. Every request tag is compared against the tags of all resident lines in parallel. On a hit the access finishes inside the cache and the memory port stays idle.

On a miss the cache picks a line to replace. Any invalid line is taken first, and otherwise the least recently used line is taken. If the victim holds modified data, it is first written back as a four-beat burst, byte 0 first. The missing line is then fetched as a four-beat burst, also byte 0 first. The request is completed only after that: a read returns the requested byte, and a write merges its byte into the fresh line and marks it modified.

The request and response ports are valid/ready channels. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the cache is idle, so it stays low from acceptance until the response has been taken. A response is held, unchanged, until `rsp_ready` is high. The memory command and write-data channels are valid/ready as well: the cache holds each command and each write beat stable until the memory side accepts it. Fill data arrives on `mem_rd_valid` with no back-pressure, because the cache always takes a fill beat during a fill.

Top module: `fa_cache`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_cmd_valid` and `mem_wr_valid` are 0. No memory channel is active while `req_ready` is high.
- R2: A read that hits raises `rsp_valid` one cycle after acceptance, carries the stored byte, and issues no memory command.
- R3: A write that hits updates the stored byte with no memory traffic. A later read of that address returns the new byte.
- R4: A read miss issues one read command (`mem_cmd_write`=0) whose `mem_cmd_line` is `req_addr[11:2]`. It then takes four fill beats as bytes 0,1,2,3 of the line and returns the requested byte. `req_ready` stays low throughout.
- R5: A write miss fetches the line first, then merges the written byte and marks the line modified. Bytes of the line that were not written come from memory.
- R6: The victim is the lowest-numbered invalid line while one exists. Once all lines are valid, the victim is the line least recently hit or filled.
- R7: A modified victim is written back before the fill. The write command (`mem_cmd_write`=1) carries the victim's line address and is followed by four beats, bytes 0..3, that hold the modified data.
- R8: A victim that was never written is replaced with no write-back command.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` stays low.
- R10: `mem_cmd_valid` and its line and direction hold until `mem_cmd_ready`. `mem_wr_valid` and `mem_wr_data` hold until `mem_wr_ready`.
- R11: No two valid lines ever hold the same tag, so a rewritten and reread address resolves to a single line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache idle and able to accept |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 8 | Read byte (written byte for writes) |
| mem_cmd_valid | output | 1 | Burst command present |
| mem_cmd_ready | input | 1 | Burst command accepted |
| mem_cmd_write | output | 1 | 1 = write-back burst, 0 = fill burst |
| mem_cmd_line | output | 10 | Line address of the burst |
| mem_wr_valid | output | 1 | Write-back beat present |
| mem_wr_ready | input | 1 | Write-back beat accepted |
| mem_wr_data | output | 8 | Write-back byte |
| mem_rd_valid | input | 1 | Fill beat present |
| mem_rd_data | input | 8 | Fill byte |

## Verification
The bench builds the cache with its default parameters: eight lines of four bytes and a 12-bit address. With only eight lines, every line can be made valid with eight distinct tags in a few requests. A single extra hit then fixes which line is least recently used, so the next miss is forced onto a known modified victim. A further miss then lands on a known clean victim. The memory model delays each command by one cycle, which exercises the hold rules, and the response channel is stalled once.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB_CMD,
    ST_WB_DATA,
    ST_FILL_CMD,
    ST_FILL_DATA,
    ST_FINISH,
    ST_RESP
  } ctl_state_t;
endpackage

// File: rtl/cam_tag_dir.sv
module cam_tag_dir #(
  parameter int LINES = 8,
  parameter int TAG_W = 10,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lookup_tag,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [LINES-1:0] hit_vec,
  output logic [LINES-1:0] valid_vec,
  output logic [LINES-1:0] dirty_vec
);
  logic [TAG_W-1:0] tag_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [TAG_W-1:0] tag_q;
    logic             valid_q;
    logic             dirty_q;
    logic             sel_alloc;
    logic             sel_dirty;

    assign sel_alloc = alloc_en && (alloc_idx == IDX_W'(g));
    assign sel_dirty = dirty_en && (dirty_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
        tag_q   <= '0;
      end else if (sel_alloc) begin
        valid_q <= 1'b1;
        dirty_q <= 1'b0;
        tag_q   <= alloc_tag;
      end else if (sel_dirty) begin
        dirty_q <= 1'b1;
      end
    end

    assign hit_vec[g]   = valid_q && (tag_q == lookup_tag);
    assign valid_vec[g] = valid_q;
    assign dirty_vec[g] = dirty_q;
    assign tag_arr[g]   = tag_q;
  end

  assign rd_tag = tag_arr[rd_idx];
endmodule

// File: rtl/lru_ages.sv
module lru_ages #(
  parameter int LINES = 8,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic [LINES-1:0] valid_vec,
  output logic [IDX_W-1:0] victim_idx,
  output logic [LINES-1:0] oldest_vec
);
  localparam logic [IDX_W-1:0] MAX_AGE = IDX_W'(LINES - 1);

  logic [IDX_W-1:0] age_q [LINES];
  logic [IDX_W-1:0] touched_age;

  assign touched_age = age_q[touch_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == touch_idx)      age_q[i] <= '0;
        else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_old
    assign oldest_vec[g] = (age_q[g] == MAX_AGE);
  end

  always_comb begin
    logic found;
    found      = 1'b0;
    victim_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!found && !valid_vec[i]) begin
        victim_idx = IDX_W'(i);
        found      = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < LINES; i++) begin
        if (oldest_vec[i]) victim_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/line_store.sv
module line_store #(
  parameter int LINES  = 8,
  parameter int OFFS_W = 2,
  parameter int DATA_W = 8,
  parameter int IDX_W  = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [OFFS_W-1:0] w_off,
  input  logic [DATA_W-1:0] w_data,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [OFFS_W-1:0] ra_off,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [OFFS_W-1:0] rb_off,
  output logic [DATA_W-1:0] rb_data
);
  localparam int DEPTH = LINES << OFFS_W;

  logic [DATA_W-1:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) bytes_q[{w_idx, w_off}] <= w_data;
  end

  assign ra_data = bytes_q[{ra_idx, ra_off}];
  assign rb_data = bytes_q[{rb_idx, rb_off}];
endmodule

// File: rtl/fa_cache.sv
module fa_cache #(
  parameter int ADDR_W = 12,
  parameter int OFFS_W = 2,
  parameter int DATA_W = 8,
  parameter int LINES  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 mem_cmd_valid,
  input  logic                 mem_cmd_ready,
  output logic                 mem_cmd_write,
  output logic [ADDR_W-OFFS_W-1:0] mem_cmd_line,
  output logic                 mem_wr_valid,
  input  logic                 mem_wr_ready,
  output logic [DATA_W-1:0]    mem_wr_data,
  input  logic                 mem_rd_valid,
  input  logic [DATA_W-1:0]    mem_rd_data
);
  import cache_pkg::*;

  localparam int LINE_W = ADDR_W - OFFS_W;
  localparam int IDX_W  = $clog2(LINES);
  localparam logic [OFFS_W-1:0] LAST_BEAT = {OFFS_W{1'b1}};

  ctl_state_t        state_q;
  logic              q_write;
  logic [ADDR_W-1:0] q_addr;
  logic [DATA_W-1:0] q_wdata;
  logic [IDX_W-1:0]  vict_q;
  logic [OFFS_W-1:0] beat_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic [LINE_W-1:0] lookup_tag;
  logic [LINES-1:0]  hit_vec, valid_vec, dirty_vec, oldest_vec;
  logic              hit_any;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [LINE_W-1:0] vict_tag;
  logic              accept, hit_accept, miss_accept;
  logic              fill_beat, fill_last;

  logic              st_we;
  logic [IDX_W-1:0]  st_widx;
  logic [OFFS_W-1:0] st_woff;
  logic [DATA_W-1:0] st_wdata;
  logic [IDX_W-1:0]  ra_idx;
  logic [OFFS_W-1:0] ra_off;
  logic [DATA_W-1:0] ra_data;
  logic              touch_en, dirty_en;
  logic [IDX_W-1:0]  touch_idx;

  assign req_ready   = (state_q == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign lookup_tag  = (state_q == ST_IDLE) ? req_addr[ADDR_W-1:OFFS_W]
                                            : q_addr[ADDR_W-1:OFFS_W];
  assign hit_any     = |hit_vec;
  assign hit_accept  = accept && hit_any;
  assign miss_accept = accept && !hit_any;
  assign fill_beat   = (state_q == ST_FILL_DATA) && mem_rd_valid;
  assign fill_last   = fill_beat && (beat_q == LAST_BEAT);

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  cam_tag_dir #(.LINES(LINES), .TAG_W(LINE_W), .IDX_W(IDX_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .lookup_tag(lookup_tag),
    .alloc_en  (fill_last),
    .alloc_idx (vict_q),
    .alloc_tag (q_addr[ADDR_W-1:OFFS_W]),
    .dirty_en  (dirty_en),
    .dirty_idx (touch_idx),
    .rd_idx    (vict_q),
    .rd_tag    (vict_tag),
    .hit_vec   (hit_vec),
    .valid_vec (valid_vec),
    .dirty_vec (dirty_vec)
  );

  assign touch_en  = hit_accept || (state_q == ST_FINISH);
  assign touch_idx = (state_q == ST_IDLE) ? hit_idx : vict_q;
  assign dirty_en  = (hit_accept && req_write) || ((state_q == ST_FINISH) && q_write);

  lru_ages #(.LINES(LINES), .IDX_W(IDX_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_idx (touch_idx),
    .valid_vec (valid_vec),
    .victim_idx(victim_idx),
    .oldest_vec(oldest_vec)
  );

  always_comb begin
    st_we    = 1'b0;
    st_widx  = vict_q;
    st_woff  = q_addr[OFFS_W-1:0];
    st_wdata = q_wdata;
    if (hit_accept && req_write) begin
      st_we    = 1'b1;
      st_widx  = hit_idx;
      st_woff  = req_addr[OFFS_W-1:0];
      st_wdata = req_wdata;
    end else if (fill_beat) begin
      st_we    = 1'b1;
      st_woff  = beat_q;
      st_wdata = mem_rd_data;
    end else if ((state_q == ST_FINISH) && q_write) begin
      st_we    = 1'b1;
    end
  end

  assign ra_idx = (state_q == ST_IDLE) ? hit_idx : vict_q;
  assign ra_off = (state_q == ST_IDLE) ? req_addr[OFFS_W-1:0] : q_addr[OFFS_W-1:0];

  line_store #(.LINES(LINES), .OFFS_W(OFFS_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
    .clk    (clk),
    .we     (st_we),
    .w_idx  (st_widx),
    .w_off  (st_woff),
    .w_data (st_wdata),
    .ra_idx (ra_idx),
    .ra_off (ra_off),
    .ra_data(ra_data),
    .rb_idx (vict_q),
    .rb_off (beat_q),
    .rb_data(mem_wr_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      q_write    <= 1'b0;
      q_addr     <= '0;
      q_wdata    <= '0;
      vict_q     <= '0;
      beat_q     <= '0;
      rsp_data_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (hit_accept) begin
            rsp_data_q <= req_write ? req_wdata : ra_data;
            state_q    <= ST_RESP;
          end else if (miss_accept) begin
            q_write <= req_write;
            q_addr  <= req_addr;
            q_wdata <= req_wdata;
            vict_q  <= victim_idx;
            beat_q  <= '0;
            state_q <= (valid_vec[victim_idx] && dirty_vec[victim_idx]) ? ST_WB_CMD
                                                                      : ST_FILL_CMD;
          end
        end
        ST_WB_CMD: begin
          if (mem_cmd_ready) state_q <= ST_WB_DATA;
        end
        ST_WB_DATA: begin
          if (mem_wr_ready) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_FILL_CMD;
          end
        end
        ST_FILL_CMD: begin
          if (mem_cmd_ready) state_q <= ST_FILL_DATA;
        end
        ST_FILL_DATA: begin
          if (mem_rd_valid) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == LAST_BEAT) state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          rsp_data_q <= q_write ? q_wdata : ra_data;
          state_q    <= ST_RESP;
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_rdata     = rsp_data_q;
  assign mem_cmd_valid = (state_q == ST_WB_CMD) || (state_q == ST_FILL_CMD);
  assign mem_cmd_write = (state_q == ST_WB_CMD);
  assign mem_cmd_line  = (state_q == ST_WB_CMD) ? vict_tag : q_addr[ADDR_W-1:OFFS_W];
  assign mem_wr_valid  = (state_q == ST_WB_DATA);
endmodule

// File: rtl/fa_cache_chk.sv
module fa_cache_chk #(
  parameter int LINES  = 8,
  parameter int LINE_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              mem_cmd_valid,
  input logic              mem_cmd_ready,
  input logic              mem_cmd_write,
  input logic [LINE_W-1:0] mem_cmd_line,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [DATA_W-1:0] mem_wr_data,
  input logic              mem_rd_valid,
  input logic [LINES-1:0]  hit_vec,
  input logic [LINES-1:0]  oldest_vec,
  input logic              hit_accept
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_cmd_valid && !mem_wr_valid && !rsp_valid));

  p_hit_nomem_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> (rsp_valid && !mem_cmd_valid));

  p_fill_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !req_ready);

  p_one_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest_vec) == 1);

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && !req_ready));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_line) && $stable(mem_cmd_write)));

  p_wr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_data)));

  p_unique_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

bind fa_cache fa_cache_chk #(.LINES(LINES), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .mem_cmd_valid(mem_cmd_valid),
  .mem_cmd_ready(mem_cmd_ready),
  .mem_cmd_write(mem_cmd_write),
  .mem_cmd_line (mem_cmd_line),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_data  (mem_wr_data),
  .mem_rd_valid (mem_rd_valid),
  .hit_vec      (hit_vec),
  .oldest_vec   (oldest_vec),
  .hit_accept   (hit_accept)
);

// File: tb/fa_cache_test.sv
module fa_cache_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready, req_write;
  logic [11:0] req_addr;
  logic [7:0] req_wdata;
  logic       rsp_valid, rsp_ready;
  logic [7:0] rsp_rdata;
  logic       mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [9:0] mem_cmd_line;
  logic       mem_wr_valid, mem_wr_ready;
  logic [7:0] mem_wr_data;
  logic       mem_rd_valid;
  logic [7:0] mem_rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;
  int fill_cnt = 0;
  int wb_cnt   = 0;
  logic [9:0] last_fill_line = '0;
  logic [9:0] last_wb_line   = '0;
  logic       prev_wb        = 1'b0;
  logic       fill_after_wb  = 1'b0;

  logic [7:0] mem_img [4096];
  logic [7:0] ref_img [4096];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fa_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_write(mem_cmd_write), .mem_cmd_line(mem_cmd_line),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] init_byte(int a);
    logic [11:0] v;
    v = 12'(a);
    return v[7:0] ^ {v[11:8], v[11:8]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compare each response as it is handed over.
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "unexpected response", int'(rsp_rdata), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, int'(rsp_rdata), int'(e));
      end
      done_cnt++;
    end
  end

  // Memory model: one-cycle command delay, four-beat bursts, byte 0 first.
  initial begin
    mem_cmd_ready = 1'b0;
    mem_wr_ready  = 1'b0;
    mem_rd_valid  = 1'b0;
    mem_rd_data   = '0;
    for (int i = 0; i < 4096; i++) begin
      mem_img[i] = init_byte(i);
      ref_img[i] = init_byte(i);
    end
    forever begin
      @(negedge clk);
      if (rst_n && mem_cmd_valid) begin
        logic [9:0] cl;
        logic       cw;
        cl = mem_cmd_line;
        cw = mem_cmd_write;
        @(negedge clk);
        chk(mem_cmd_valid && mem_cmd_line == cl && mem_cmd_write == cw,
            "R10 command held", int'(mem_cmd_line), int'(cl));
        mem_cmd_ready = 1'b1;
        @(negedge clk);
        mem_cmd_ready = 1'b0;
        if (cw) begin
          wb_cnt++;
          last_wb_line = cl;
          prev_wb = 1'b1;
          mem_wr_ready = 1'b1;
          for (int b = 0; b < 4; b++) begin
            while (!mem_wr_valid) @(negedge clk);
            mem_img[{cl, 2'(b)}] = mem_wr_data;
            @(negedge clk);
          end
          mem_wr_ready = 1'b0;
        end else begin
          fill_cnt++;
          last_fill_line = cl;
          fill_after_wb = prev_wb;
          prev_wb = 1'b0;
          for (int b = 0; b < 4; b++) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = mem_img[{cl, 2'(b)}];
            @(negedge clk);
          end
          mem_rd_valid = 1'b0;
        end
      end
    end
  end

  // Driver: push expectation, issue request, wait for its response.
  task automatic issue(input bit w, input logic [11:0] a, input logic [7:0] d, input string tag);
    logic [7:0] e;
    e = w ? d : ref_img[a];
    if (w) ref_img[a] = d;
    exp_q.push_back(e);
    tag_q.push_back({tag, " data"});
    @(negedge clk);
    req_valid = 1'b1;
    req_write = w;
    req_addr  = a;
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic access(input bit w, input logic [11:0] a, input logic [7:0] d,
                        input int exp_fills, input int exp_wbs, input string tag);
    int f0, w0, target;
    f0 = fill_cnt;
    w0 = wb_cnt;
    target = done_cnt + 1;
    issue(w, a, d, tag);
    while (done_cnt < target) @(negedge clk);
    chk(fill_cnt - f0 == exp_fills, {tag, " fills"}, fill_cnt - f0, exp_fills);
    chk(wb_cnt - w0 == exp_wbs, {tag, " writebacks"}, wb_cnt - w0, exp_wbs);
  endtask

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_addr  = '0;
    req_wdata = '0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    chk(!rsp_valid && !mem_cmd_valid && !mem_wr_valid, "R1 outputs idle after reset",
        int'({rsp_valid, mem_cmd_valid, mem_wr_valid}), 0);

    // R4: read miss fills line 0x40
    access(1'b0, 12'h100, 8'h00, 1, 0, "R4 read miss");
    chk(last_fill_line == 10'h040, "R4 fill line", int'(last_fill_line), 'h40);
    // R2: read hit in filled line
    access(1'b0, 12'h103, 8'h00, 0, 0, "R2 read hit");
    // R3: write hit then read back
    access(1'b1, 12'h101, 8'hAA, 0, 0, "R3 write hit");
    access(1'b0, 12'h101, 8'h00, 0, 0, "R3 read after write");
    // R5: write miss allocates and merges
    access(1'b1, 12'h204, 8'h55, 1, 0, "R5 write miss");
    chk(last_fill_line == 10'h081, "R5 fill line", int'(last_fill_line), 'h81);
    access(1'b0, 12'h205, 8'h00, 0, 0, "R5 unwritten byte from memory");
    access(1'b0, 12'h204, 8'h00, 0, 0, "R5 merged byte");
    // R6: invalid lines used before any eviction
    for (int k = 3; k <= 8; k++) begin
      access(1'b0, 12'(k << 8), 8'h00, 1, 0, "R6 fill into invalid line");
    end
    access(1'b0, 12'h102, 8'h00, 0, 0, "R6 first line still resident");
    // R7: LRU line 0x081 is dirty and gets written back before the fill
    access(1'b0, 12'h900, 8'h00, 1, 1, "R7 dirty victim");
    chk(last_wb_line == 10'h081, "R7 write-back line", int'(last_wb_line), 'h81);
    chk(fill_after_wb == 1'b1, "R7 write-back precedes fill", int'(fill_after_wb), 1);
    chk(last_fill_line == 10'h240, "R7 fill line after write-back", int'(last_fill_line), 'h240);
    chk(mem_img[12'h204] == 8'h55, "R7 written-back byte", int'(mem_img[12'h204]), 'h55);
    // R8: next victim (line 0x0C0) is clean
    access(1'b0, 12'h204, 8'h00, 1, 0, "R8 clean victim");
    chk(last_fill_line == 10'h081, "R8 refill line", int'(last_fill_line), 'h81);
    chk(fill_after_wb == 1'b0, "R8 no write-back before fill", int'(fill_after_wb), 0);
    // R6: recently used line survived both evictions
    access(1'b0, 12'h101, 8'h00, 0, 0, "R6 recently used line kept");

    // R9: response stalled
    rsp_ready = 1'b0;
    fork
      issue(1'b0, 12'h103, 8'h00, "R9 stalled response");
      begin
        while (!rsp_valid) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          chk(rsp_valid == 1'b1, "R9 rsp_valid held", int'(rsp_valid), 1);
          chk(rsp_rdata == ref_img[12'h103], "R9 rsp_rdata held",
              int'(rsp_rdata), int'(ref_img[12'h103]));
          chk(req_ready == 1'b0, "R9 req_ready low while stalled", int'(req_ready), 0);
        end
        rsp_ready = 1'b1;
      end
    join
    while (exp_q.size() != 0) @(negedge clk);

    // R11: rewrite within a resident line resolves to one line
    access(1'b1, 12'h206, 8'h77, 0, 0, "R11 write resident");
    access(1'b0, 12'h206, 8'h00, 0, 0, "R11 reread");
    access(1'b0, 12'h204, 8'h00, 0, 0, "R11 neighbour byte");

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule